// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block resolves a single instruction operand according to one of ten addressing modes. A start pulse hands it a 4-bit mode code, the instruction's constant field, a register number and the current program counter. It reads the selected register from an external register file and forms the effective address. It then issues the zero, one or two data-memory reads that the mode needs, over a request/valid handshake. When the operand is ready it returns the operand, the effective address and the number of reads it used, and it pulses `done`.

The two stepping modes update the selected register through a register-file write port. The step is one element: 1 for byte accesses and 4 for word accesses. Post-increment reads at the old register value and then steps it. Pre-decrement steps first and reads at the new value. The block keeps one operand in flight at a time. A start that arrives while it is busy is dropped.

Top module: `opfetch_unit`

## Requirements
- R1: After reset, `done`, `mem_req`, `rf_we`, `illegal` and `busy` are all 0.
- R2: Mode 0 (immediate) returns the field zero-extended as the operand. It reports `eff_addr` 0 and an access count of 0, and it issues no memory request, even when the field is 0.
- R3: Mode 1 (direct) uses the zero-extended field as the effective address and performs exactly one read. The data read is the operand.
- R4: Mode 2 (indirect) reads a pointer at the zero-extended field address, then reads the operand at that pointer. It performs two reads. The pointer is the reported effective address, and it is followed exactly once even when the cell holds its own address.
- R5: Mode 3 (register) returns the register contents with zero reads and `eff_addr` 0. Mode 4 (register-indirect) reads once, at the address held in the register.
- R6: Modes 5 (displacement) and 6 (indexed) both read once, at the sign-extended field plus the register contents.
- R7: Mode 7 (PC-relative) reads once, at the program counter plus the sign-extended field. A zero field addresses the program counter itself.
- R8: Mode 8 (post-increment) reads once at the register's current value. It then writes the register value plus the step back to the same register.
- R9: Mode 9 (pre-decrement) subtracts the step from the register, reads once at the result, and writes the result back. The subtraction wraps modulo 2^16 with no bounds check.
- R10: The step is 1 when `word_in` is 0 and 4 when `word_in` is 1.
- R11: Codes 10 to 15 finish with `illegal` 1 and the operand, `eff_addr` and access count all 0. They issue no memory request and no register write.
- R12: `done` is a one-cycle pulse. `rf_we` is high only in the `done` cycle of modes 8 and 9. A `start` that arrives while `busy` is 1 is ignored.
- R13: Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is seen. `mem_req` is high only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving an operand; taken only while idle |
| mode_in | input | 4 | Addressing-mode code |
| field_in | input | FIELD_W (8) | Constant/address/displacement field |
| reg_in | input | REG_AW (3) | Register number |
| pc_in | input | ADDR_W (16) | Program counter |
| word_in | input | 1 | Element size: 0 byte, 1 word |
| rf_raddr | output | REG_AW | Register-file read address |
| rf_rdata | input | DATA_W (16) | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_AW | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| mem_req | output | 1 | Data-memory read request |
| mem_addr | output | ADDR_W | Data-memory read address |
| mem_valid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Unit is resolving an operand |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Mode code was unused; valid with done |
| operand | output | DATA_W | Resolved operand; valid with done |
| eff_addr | output | ADDR_W | Effective address; valid with done |
| access_cnt | output | 2 | Memory reads used; valid with done |

## Verification
A bad captured mode, or a bad address sum, shows up at the first memory request: a wrong `mem_addr` appears within two cycles of start, before any data returns. A sequencer that loses its place shows as a read count at `done` that differs from the mode's fixed count. It can also show as a missing second request, or as a `done` that never comes. The bench watches for all of these on every operation. A wrong step or a wrong write target only shows in the `done` cycle, on `rf_wdata` and `rf_waddr`. The bench checks them there and compares the register it models in the following operations.

// File: rtl/opf_pkg.sv
package opf_pkg;

   typedef enum logic [3:0] {
      MD_IMM   = 4'd0,
      MD_DIR   = 4'd1,
      MD_IND   = 4'd2,
      MD_REG   = 4'd3,
      MD_RIND  = 4'd4,
      MD_DISP  = 4'd5,
      MD_IDX   = 4'd6,
      MD_PCREL = 4'd7,
      MD_AINC  = 4'd8,
      MD_ADEC  = 4'd9
   } opf_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_RD1  = 2'd2,
      ST_RD2  = 2'd3
   } opf_state_e;

   function automatic logic mode_legal(input logic [3:0] m);
      return m <= 4'(MD_ADEC);
   endfunction

   function automatic logic [1:0] mode_reads(input logic [3:0] m);
      logic [1:0] n;
      case (m)
         4'(MD_IMM), 4'(MD_REG): n = 2'd0;
         4'(MD_IND):             n = 2'd2;
         default:                n = mode_legal(m) ? 2'd1 : 2'd0;
      endcase
      return n;
   endfunction

   function automatic logic mode_steps(input logic [3:0] m);
      return (m == 4'(MD_AINC)) || (m == 4'(MD_ADEC));
   endfunction

endpackage

// File: rtl/opf_field_ext.sv
module opf_field_ext #(
   parameter int FIELD_W    = 8,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  logic [FIELD_W-1:0] field,
   output logic [ADDR_W-1:0]  field_s,
   output logic [ADDR_W-1:0]  field_z,
   output logic [DATA_W-1:0]  imm_val
);
   localparam int AEXT = ADDR_W - FIELD_W;
   localparam int DEXT = DATA_W - FIELD_W;

   assign field_s = {{AEXT{field[FIELD_W-1]}}, field};
   assign field_z = {{AEXT{1'b0}}, field};

   generate
      if (IMM_SIGNED) begin : g_imm_signed
         assign imm_val = {{DEXT{field[FIELD_W-1]}}, field};
      end else begin : g_imm_unsigned
         assign imm_val = {{DEXT{1'b0}}, field};
      end
   endgenerate
endmodule

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
   import opf_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic [3:0]        mode,
   input  logic              word,
   input  logic [ADDR_W-1:0] field_s,
   input  logic [ADDR_W-1:0] field_z,
   input  logic [ADDR_W-1:0] pc,
   input  logic [DATA_W-1:0] reg_val,
   output logic [ADDR_W-1:0] ea,
   output logic [DATA_W-1:0] wb_val
);
   logic [DATA_W-1:0] step;
   logic [DATA_W-1:0] reg_inc;
   logic [DATA_W-1:0] reg_dec;
   logic [ADDR_W-1:0] reg_a;

   assign step    = word ? DATA_W'(WORD_BYTES) : DATA_W'(1);
   assign reg_inc = reg_val + step;
   assign reg_dec = reg_val - step;
   assign reg_a   = reg_val[ADDR_W-1:0];
   assign wb_val  = (mode == 4'(MD_ADEC)) ? reg_dec : reg_inc;

   always_comb begin
      case (mode)
         4'(MD_DIR), 4'(MD_IND):   ea = field_z;
         4'(MD_RIND), 4'(MD_AINC): ea = reg_a;
         4'(MD_DISP), 4'(MD_IDX):  ea = field_s + reg_a;
         4'(MD_PCREL):             ea = pc + field_s;
         4'(MD_ADEC):              ea = reg_dec[ADDR_W-1:0];
         default:                  ea = '0;
      endcase
   end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
   import opf_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int REG_AW  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode_in,
   input  logic [FIELD_W-1:0] field_in,
   input  logic [REG_AW-1:0]  reg_in,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic               word_in,
   output logic [3:0]         q_mode,
   output logic [FIELD_W-1:0] q_field,
   output logic [REG_AW-1:0]  q_reg,
   output logic [ADDR_W-1:0]  q_pc,
   output logic               q_word,
   input  logic [ADDR_W-1:0]  ea,
   input  logic [DATA_W-1:0]  wb_val,
   input  logic [DATA_W-1:0]  imm_val,
   input  logic [DATA_W-1:0]  reg_val,
   output logic               rf_we,
   output logic [DATA_W-1:0]  rf_wdata,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_valid,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               busy,
   output logic               done,
   output logic               illegal,
   output logic [DATA_W-1:0]  operand,
   output logic [ADDR_W-1:0]  eff_addr,
   output logic [1:0]         access_cnt
);
   opf_state_e        state;
   logic [DATA_W-1:0] wb_hold;
   logic              last_read;

   assign busy      = (state != ST_IDLE);
   assign last_read = (state == ST_RD2) || (q_mode != 4'(MD_IND));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         q_mode     <= '0;
         q_field    <= '0;
         q_reg      <= '0;
         q_pc       <= '0;
         q_word     <= 1'b0;
         wb_hold    <= '0;
         rf_we      <= 1'b0;
         rf_wdata   <= '0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         done       <= 1'b0;
         illegal    <= 1'b0;
         operand    <= '0;
         eff_addr   <= '0;
         access_cnt <= '0;
      end else begin
         done  <= 1'b0;
         rf_we <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  q_mode  <= mode_in;
                  q_field <= field_in;
                  q_reg   <= reg_in;
                  q_pc    <= pc_in;
                  q_word  <= word_in;
                  state   <= ST_CALC;
               end
            end
            ST_CALC: begin
               access_cnt <= '0;
               illegal    <= !mode_legal(q_mode);
               if (mode_reads(q_mode) == 2'd0) begin
                  eff_addr <= '0;
                  done     <= 1'b1;
                  state    <= ST_IDLE;
                  if (q_mode == 4'(MD_IMM))      operand <= imm_val;
                  else if (q_mode == 4'(MD_REG)) operand <= reg_val;
                  else                           operand <= '0;
               end else begin
                  eff_addr <= ea;
                  mem_addr <= ea;
                  mem_req  <= 1'b1;
                  wb_hold  <= wb_val;
                  state    <= ST_RD1;
               end
            end
            default: begin
               if (mem_valid) begin
                  access_cnt <= access_cnt + 2'd1;
                  if (last_read) begin
                     mem_req  <= 1'b0;
                     operand  <= mem_rdata;
                     done     <= 1'b1;
                     rf_we    <= mode_steps(q_mode);
                     rf_wdata <= wb_hold;
                     state    <= ST_IDLE;
                  end else begin
                     mem_addr <= mem_rdata[ADDR_W-1:0];
                     eff_addr <= mem_rdata[ADDR_W-1:0];
                     state    <= ST_RD2;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
   import opf_pkg::*;
#(
   parameter int FIELD_W    = 8,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int REG_AW     = 3,
   parameter int WORD_BYTES = 4,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [3:0]         mode_in,
   input  logic [FIELD_W-1:0] field_in,
   input  logic [REG_AW-1:0]  reg_in,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic               word_in,
   output logic [REG_AW-1:0]  rf_raddr,
   input  logic [DATA_W-1:0]  rf_rdata,
   output logic               rf_we,
   output logic [REG_AW-1:0]  rf_waddr,
   output logic [DATA_W-1:0]  rf_wdata,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_valid,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               busy,
   output logic               done,
   output logic               illegal,
   output logic [DATA_W-1:0]  operand,
   output logic [ADDR_W-1:0]  eff_addr,
   output logic [1:0]         access_cnt
);
   generate
      if (FIELD_W >= ADDR_W) begin : g_bad_field
         $error("opfetch_unit: FIELD_W must be narrower than ADDR_W");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("opfetch_unit: a pointer read from memory must fit ADDR_W in DATA_W");
      end
      if (WORD_BYTES < 1) begin : g_bad_step
         $error("opfetch_unit: WORD_BYTES must be positive");
      end
   endgenerate

   logic [3:0]         q_mode;
   logic [FIELD_W-1:0] q_field;
   logic [REG_AW-1:0]  q_reg;
   logic [ADDR_W-1:0]  q_pc;
   logic               q_word;
   logic [ADDR_W-1:0]  field_s;
   logic [ADDR_W-1:0]  field_z;
   logic [DATA_W-1:0]  imm_val;
   logic [ADDR_W-1:0]  ea;
   logic [DATA_W-1:0]  wb_val;

   assign rf_raddr = q_reg;
   assign rf_waddr = q_reg;

   opf_field_ext #(
      .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_SIGNED(IMM_SIGNED)
   ) u_ext (
      .field(q_field), .field_s(field_s), .field_z(field_z), .imm_val(imm_val)
   );

   opf_ea_calc #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
   ) u_ea (
      .mode(q_mode), .word(q_word), .field_s(field_s), .field_z(field_z),
      .pc(q_pc), .reg_val(rf_rdata), .ea(ea), .wb_val(wb_val)
   );

   opf_ctrl #(
      .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
      .field_in(field_in), .reg_in(reg_in), .pc_in(pc_in), .word_in(word_in),
      .q_mode(q_mode), .q_field(q_field), .q_reg(q_reg), .q_pc(q_pc),
      .q_word(q_word), .ea(ea), .wb_val(wb_val), .imm_val(imm_val),
      .reg_val(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .illegal(illegal),
      .operand(operand), .eff_addr(eff_addr), .access_cnt(access_cnt)
   );
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              illegal,
   input logic [1:0]        access_cnt,
   input logic              rf_we,
   input logic              mem_req,
   input logic              mem_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy
);
   assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

   assert_req_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |-> (access_cnt == 2'd0 && !rf_we));

   assert_step_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (done && access_cnt == 2'd1 && !illegal));

   assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (access_cnt != 2'd3));
endmodule

bind opfetch_unit opf_checker #(.ADDR_W(ADDR_W)) u_opf_checker (
   .clk(clk), .rst_n(rst_n), .done(done), .illegal(illegal),
   .access_cnt(access_cnt), .rf_we(rf_we), .mem_req(mem_req),
   .mem_valid(mem_valid), .mem_addr(mem_addr), .busy(busy)
);

// File: tb/test_opfetch_unit.sv
module test_opfetch_unit;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] SELF_CELL = 16'h0033;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode_in = '0;
   logic [7:0]  field_in = '0;
   logic [2:0]  reg_in = '0;
   logic [15:0] pc_in = '0;
   logic        word_in = 1'b0;
   logic [2:0]  rf_raddr;
   logic [15:0] rf_rdata;
   logic        rf_we;
   logic [2:0]  rf_waddr;
   logic [15:0] rf_wdata;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        busy, done, illegal;
   logic [15:0] operand, eff_addr;
   logic [1:0]  access_cnt;

   logic [15:0] regs [8];
   int          n_tests = 0;
   int          n_fail = 0;

   assign rf_rdata = regs[rf_raddr];

   always #(CLK_PERIOD/2) clk = ~clk;

   opfetch_unit i_opfetch_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
      .field_in(field_in), .reg_in(reg_in), .pc_in(pc_in), .word_in(word_in),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .illegal(illegal), .operand(operand),
      .eff_addr(eff_addr), .access_cnt(access_cnt)
   );

   function automatic logic [15:0] mem_fn(input logic [15:0] a);
      if (a == SELF_CELL) return a;
      return (a ^ 16'hA5C3) + 16'h0101;
   endfunction

   function automatic string req_of(input logic [3:0] m);
      case (m)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3, 4'd4: return "R5";
         4'd5, 4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         4'd9: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic init_regs();
      for (int i = 0; i < 8; i++) regs[i] = 16'(i * 16'h1357);
      regs[6] = SELF_CELL;
   endtask

   task automatic run_op(input logic [3:0] m, input logic [7:0] f,
                         input logic [2:0] r, input logic [15:0] pc,
                         input logic w, input int lat, input bit spur);
      logic [15:0] sx, zx, rv, st, e_op, e_ea, e_wb, p;
      logic [1:0]  e_n;
      logic        e_ill, e_we;
      int          reads, waitc, cyc;
      bit          got;
      string       rq;
      rq = req_of(m);
      sx = {{8{f[7]}}, f};
      zx = {8'h00, f};
      rv = regs[r];
      st = w ? 16'd4 : 16'd1;
      e_op = 0; e_ea = 0; e_n = 0; e_ill = 0; e_we = 0; e_wb = 0;
      case (m)
         4'd0: e_op = zx;
         4'd1: begin e_ea = zx; e_n = 1; end
         4'd2: begin p = mem_fn(zx); e_ea = p; e_n = 2; end
         4'd3: e_op = rv;
         4'd4: begin e_ea = rv; e_n = 1; end
         4'd5, 4'd6: begin e_ea = sx + rv; e_n = 1; end
         4'd7: begin e_ea = pc + sx; e_n = 1; end
         4'd8: begin e_ea = rv; e_n = 1; e_we = 1; e_wb = rv + st; end
         4'd9: begin e_ea = rv - st; e_n = 1; e_we = 1; e_wb = rv - st; end
         default: e_ill = 1;
      endcase
      if (e_n != 0) e_op = mem_fn(e_ea);

      @(negedge clk);
      mode_in = m; field_in = f; reg_in = r; pc_in = pc; word_in = w; start = 1'b1;
      reads = 0; waitc = 0; cyc = 0; got = 0;
      while (!got && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) begin
            // R12: a start seen while busy must leave this operation unchanged
            start = spur;
            mode_in = 4'd3; field_in = ~f; reg_in = r + 3'd1; pc_in = ~pc;
         end else begin
            start = 1'b0;
         end
         if (mem_valid) begin
            mem_valid = 1'b0; waitc = 0;
         end
         if (done) begin
            got = 1;
            check(rq, "operand", 32'(operand), 32'(e_op));
            check(rq, "eff_addr", 32'(eff_addr), 32'(e_ea));
            check(rq, "access_cnt", 32'(access_cnt), 32'(e_n));
            check("R11", "illegal", 32'(illegal), 32'(e_ill));
            check(rq, "observed reads", 32'(reads), 32'(e_n));
            check("R12", "rf_we", 32'(rf_we), 32'(e_we));
            if (e_we) begin
               check(w ? "R10" : rq, "rf_waddr", 32'(rf_waddr), 32'(r));
               check(w ? "R10" : rq, "rf_wdata", 32'(rf_wdata), 32'(e_wb));
               regs[r] = e_wb;
            end
         end else if (mem_req && !mem_valid) begin
            if (reads == 0 && e_n != 0)
               check(rq, "first request address",
                     32'(mem_addr), 32'(m == 4'd2 ? zx : e_ea));
            if (waitc >= lat) begin
               mem_valid = 1'b1;
               mem_rdata = mem_fn(mem_addr);
               reads++;
            end else begin
               waitc++;
            end
         end
      end
      start = 1'b0;
      if (!got) check("R12", "done seen before watchdog", 0, 1);
      @(negedge clk);
      check("R12", "done single cycle", 32'(done), 0);
      check("R13", "request released after done", 32'(mem_req), 0);
      check("R12", "idle after done", 32'(busy), 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      init_regs();
      repeat (3) @(negedge clk);
      check("R1", "done in reset", 32'(done), 0);
      check("R1", "mem_req in reset", 32'(mem_req), 0);
      check("R1", "rf_we in reset", 32'(rf_we), 0);
      check("R1", "busy in reset", 32'(busy), 0);
      check("R1", "illegal in reset", 32'(illegal), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset release", 32'(busy), 0);

      // R4: self-pointing cell is followed once only
      run_op(4'd2, SELF_CELL[7:0], 3'd0, 16'h0000, 1'b0, 1, 1'b0);
      // R7: zero offset addresses the PC itself
      run_op(4'd7, 8'h00, 3'd0, 16'h2468, 1'b0, 0, 1'b1);
      // R9: pre-decrement of zero wraps without a bounds check (R10 word step)
      regs[0] = 16'h0000;
      run_op(4'd9, 8'h00, 3'd0, 16'h0000, 1'b1, 0, 1'b0);
      check("R9", "register wrapped", 32'(regs[0]), 32'hFFFC);
      // R8: repeated post-increment steps by one byte each time
      regs[2] = 16'h0100;
      run_op(4'd8, 8'h00, 3'd2, 16'h0000, 1'b0, 2, 1'b1);
      run_op(4'd8, 8'h00, 3'd2, 16'h0000, 1'b0, 0, 1'b0);
      check("R8", "two byte steps", 32'(regs[2]), 32'h0102);

      for (int m = 0; m < 16; m++) begin
         for (int fi = 0; fi < 4; fi++) begin
            for (int ri = 0; ri < 3; ri++) begin
               for (int w = 0; w < 2; w++) begin
                  logic [7:0] f;
                  logic [2:0] r;
                  case (fi)
                     0: f = 8'h00;
                     1: f = 8'h7F;
                     2: f = 8'h80;
                     default: f = 8'hC5;
                  endcase
                  r = (ri == 0) ? 3'd0 : (ri == 1) ? 3'd5 : 3'd7;
                  init_regs();
                  run_op(4'(m), f, r, {f, 8'h10} ^ 16'(r * 16'h0111),
                         w[0], (m + fi + w) % 3, ((m + ri) % 2) == 1);
               end
            end
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule